// File: doc/BRIEF.md
# Host Command Post-Queue Register Block

This block is the device-side register slave of a memory-mapped transport that carries commands between a host and a storage controller. The host posts each command as one 32-bit command address by writing the inbound queue register. The address goes into an inbound FIFO, which the controller logic drains through a valid/pop pair. When a command finishes, the controller logic pushes a 32-bit completion tag into an outbound FIFO. The host collects one tag per read of the outbound queue register.

Host tags are posted with their two lowest bits clear. On completion the controller may set bit 1 to show that error detail is available for that command. The block moves the tag through unchanged. A doorbell register lets the host tell the controller that the configuration table has changed.

A status register shows whether the outbound queue holds anything. A mask register gates that status onto a level interrupt line. The status bit position is a build-time parameter, because there are two board variants.

Top module: `hostq_regif`

## Requirements
- R1: After reset, `irq` is 0, `ib_valid` is 0, `ob_ready` is 1, `db_cfg` is 0 and `ib_ovf` is 0. The mask register at offset 0x34 reads 0xFFFFFFFF.
- R2: Each cycle with `reg_wr_en` high at offset 0x40 pushes `reg_wdata` into the inbound FIFO. The controller sees the entries on `ib_data` in posting order while `ib_valid` is high, and `ib_pop` removes the head.
- R3: The inbound FIFO holds DEPTH (16) entries. A write to 0x40 while it is full is dropped and sets `ib_ovf`. `ib_ovf` then stays 1 until reset.
- R4: A read of offset 0x44 returns the oldest completion tag and removes exactly one entry. This holds even when `reg_rd_en` is held high for several cycles. `reg_rdata` takes the read value one clock after the first cycle of a read and holds it until the next read starts.
- R5: A read of 0x44 while the outbound FIFO is empty returns 0xFFFFFFFF and changes nothing.
- R6: `ob_ready` is 0 when the outbound FIFO holds DEPTH entries. A cycle with `ob_push` high and `ob_ready` low has no effect.
- R7: Completion tags reach the host bit for bit unchanged, including the error flag at bit 1.
- R8: The status register at 0x30 reads 1 at bit IRQ_BIT (3 by default, 2 on the other variant) while the outbound FIFO is not empty. All its other bits read 0.
- R9: The mask register at 0x34 is read/write. `irq` is 1 exactly when the status bit is 1 and mask bit IRQ_BIT is 0.
- R10: Writing 0x20 with bit 0 set raises `db_cfg`. Writing 0 to it has no effect. `db_ack` clears the bit, but a set in the same cycle wins over the acknowledge. A read of 0x20 returns `db_cfg` in bit 0.
- R11: Reads of offset 0x40 (write-only) and of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Host register write strobe, one cycle per write |
| reg_rd_en | input | 1 | Host register read strobe, may be held |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, registered |
| ib_valid | output | 1 | Inbound FIFO has an entry |
| ib_data | output | 32 | Oldest posted command address |
| ib_pop | input | 1 | Controller removes inbound head |
| ib_ovf | output | 1 | Sticky inbound overflow flag |
| ob_push | input | 1 | Controller pushes a completion tag |
| ob_tag | input | 32 | Completion tag |
| ob_ready | output | 1 | Outbound FIFO can accept a tag |
| db_cfg | output | 1 | Configuration-update doorbell |
| db_ack | input | 1 | Controller acknowledge, clears doorbell |
| irq | output | 1 | Level interrupt to host |

## Verification
The queues are tested with directed fill-to-full and drain sequences, which expose ordering faults and the overflow and stall boundaries. Alongside these, a seeded random mix interleaves host posts, controller drains, controller pushes and host fetches, which catches pointer and count faults that only appear when pushes and pops overlap. A read of the outbound register held for three cycles, followed by a second read that must return the empty sentinel, separates a single pop from a repeated pop. Doorbell writes of 0 and 1, an acknowledge, and a set and an acknowledge in the same cycle each separate the set, hold and clear priorities. Toggling the mask with the queue full and with it empty separates the status bit from the interrupt gating.

// File: rtl/hostq_pkg.sv
package hostq_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned OFF_DOOR = 'h20;
   localparam int unsigned OFF_STAT = 'h30;
   localparam int unsigned OFF_MASK = 'h34;
   localparam int unsigned OFF_POST = 'h40;
   localparam int unsigned OFF_DONE = 'h44;
   localparam logic [DATA_W-1:0] EMPTY_WORD = '1;
endpackage

// File: rtl/hostq_fifo.sv
module hostq_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CW = AW + 1;

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("hostq_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R3 / R6: callers gate pushes with full
   assert_push_not_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R5: callers gate pops with empty
   assert_pop_not_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/hostq_irq.sv
module hostq_irq #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IRQ_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              not_empty,
   input  logic              mask_bit,
   output logic [DATA_W-1:0] status,
   output logic              irq
);
   if (IRQ_BIT != 2 && IRQ_BIT != 3) begin : g_bad_bit
      $error("hostq_irq: IRQ_BIT must be 2 or 3");
   end

   if (IRQ_BIT == 3) begin : g_var_hi
      assign status = {{(DATA_W-4){1'b0}}, not_empty, 3'b000};
   end else begin : g_var_lo
      assign status = {{(DATA_W-3){1'b0}}, not_empty, 2'b00};
   end

   assign irq = status[IRQ_BIT] & ~mask_bit;

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mask_bit |-> !irq);
   assert_one_status_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status) == int'(not_empty));
endmodule

// File: rtl/hostq_regif.sv
module hostq_regif
   import hostq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned IRQ_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_rd_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              ib_valid,
   output logic [31:0]       ib_data,
   input  logic              ib_pop,
   output logic              ib_ovf,
   input  logic              ob_push,
   input  logic [31:0]       ob_tag,
   output logic              ob_ready,
   output logic              db_cfg,
   input  logic              db_ack,
   output logic              irq
);
   if (ADDR_W < 7) begin : g_bad_addr
      $error("hostq_regif: ADDR_W too narrow for register map");
   end

   localparam logic [ADDR_W-1:0] A_DOOR = ADDR_W'(OFF_DOOR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
   localparam logic [ADDR_W-1:0] A_POST = ADDR_W'(OFF_POST);
   localparam logic [ADDR_W-1:0] A_DONE = ADDR_W'(OFF_DONE);

   logic        ib_empty, ib_full, ib_push;
   logic        ob_empty, ob_full, ob_pop, ob_do_push;
   logic [31:0] ob_head, status, mask_q, rd_mux;
   logic        rd_prev, rd_first, db_set;

   assign ib_push    = reg_wr_en && reg_addr == A_POST && !ib_full;
   assign ib_valid   = !ib_empty;
   assign ob_ready   = !ob_full;
   assign ob_do_push = ob_push && !ob_full;
   assign rd_first   = reg_rd_en && !rd_prev;
   assign ob_pop     = rd_first && reg_addr == A_DONE && !ob_empty;
   assign db_set     = reg_wr_en && reg_addr == A_DOOR && reg_wdata[0];

   hostq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_in_q (
      .clk(clk), .rst_n(rst_n), .push(ib_push), .din(reg_wdata),
      .pop(ib_pop && !ib_empty), .dout(ib_data), .empty(ib_empty), .full(ib_full));

   hostq_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_out_q (
      .clk(clk), .rst_n(rst_n), .push(ob_do_push), .din(ob_tag),
      .pop(ob_pop), .dout(ob_head), .empty(ob_empty), .full(ob_full));

   hostq_irq #(.DATA_W(DATA_W), .IRQ_BIT(IRQ_BIT)) u_irq (
      .clk(clk), .rst_n(rst_n), .not_empty(!ob_empty),
      .mask_bit(mask_q[IRQ_BIT]), .status(status), .irq(irq));

   always_comb begin
      rd_mux = '0;
      if (reg_addr == A_DOOR)      rd_mux = {31'b0, db_cfg};
      else if (reg_addr == A_STAT) rd_mux = status;
      else if (reg_addr == A_MASK) rd_mux = mask_q;
      else if (reg_addr == A_DONE) rd_mux = ob_empty ? EMPTY_WORD : ob_head;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         rd_prev   <= 1'b0;
         mask_q    <= '1;
         db_cfg    <= 1'b0;
         ib_ovf    <= 1'b0;
      end else begin
         rd_prev <= reg_rd_en;
         if (rd_first) reg_rdata <= rd_mux;
         if (reg_wr_en && reg_addr == A_MASK) mask_q <= reg_wdata;
         if (db_set)      db_cfg <= 1'b1;
         else if (db_ack) db_cfg <= 1'b0;
         if (reg_wr_en && reg_addr == A_POST && ib_full) ib_ovf <= 1'b1;
      end
   end

   assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ib_ovf |=> ib_ovf);
   assert_single_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ob_pop |=> !ob_pop);
   assert_held_read_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_en && rd_prev) |=> $stable(reg_rdata));
   assert_door_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (db_ack && !db_set) |=> !db_cfg);
   assert_door_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      db_set |=> db_cfg);
endmodule

// File: tb/tb_hostq_regif.sv
module tb_hostq_regif;
   localparam int DEPTH = 16;
   localparam int IRQ_BIT = 3;

   logic        clk = 0, rst_n = 0;
   logic        reg_wr_en = 0, reg_rd_en = 0;
   logic [7:0]  reg_addr = 0;
   logic [31:0] reg_wdata = 0, reg_rdata, ib_data, ob_tag = 0;
   logic        ib_valid, ib_pop = 0, ib_ovf, ob_push = 0, ob_ready;
   logic        db_cfg, db_ack = 0, irq;

   int total = 0, bad = 0;
   logic [31:0] inq[$], outq[$];
   logic [31:0] mask_m = 32'hFFFF_FFFF;

   always #2 clk = ~clk;

   hostq_regif #(.ADDR_W(8), .DEPTH(DEPTH), .IRQ_BIT(IRQ_BIT)) dut (.*);

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      return outq.size() > 0 ? (32'd1 << IRQ_BIT) : 32'd0;
   endfunction

   function automatic logic exp_irq();
      return outq.size() > 0 && !mask_m[IRQ_BIT];
   endfunction

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk); reg_wr_en = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr_en = 0;
   endtask

   task automatic rd(logic [7:0] a, int hold, output logic [31:0] d);
      @(negedge clk); reg_rd_en = 1; reg_addr = a;
      repeat (hold) @(posedge clk);
      @(negedge clk); reg_rd_en = 0; d = reg_rdata;
   endtask

   task automatic ctl_push(logic [31:0] t);
      @(negedge clk); ob_push = 1; ob_tag = t;
      @(negedge clk); ob_push = 0;
   endtask

   task automatic ctl_pop();
      @(negedge clk); ib_pop = 1;
      @(negedge clk); ib_pop = 0;
   endtask

   task automatic host_post(logic [31:0] d);
      wr(8'h40, d);
      if (inq.size() < DEPTH) inq.push_back(d);
   endtask

   task automatic host_fetch(int hold);
      logic [31:0] d, e;
      e = outq.size() > 0 ? outq.pop_front() : 32'hFFFF_FFFF;
      rd(8'h44, hold, d);
      chk("R4/R5 fetch", d, e);
   endtask

   task automatic drain_check(string req);
      chk({req, " ib_valid"}, 32'(ib_valid), 32'(inq.size() > 0));
      if (inq.size() > 0) begin
         chk({req, " ib_data"}, ib_data, inq.pop_front());
         ctl_pop();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      chk("R1 ib_valid", 32'(ib_valid), 0);
      chk("R1 ob_ready", 32'(ob_ready), 1);
      chk("R1 db_cfg", 32'(db_cfg), 0);
      chk("R1 ib_ovf", 32'(ib_ovf), 0);
      @(negedge clk); rst_n = 1;
      rd(8'h34, 1, d); chk("R1 mask reset", d, 32'hFFFF_FFFF);

      // R8 R9 R7 R4 R5
      ctl_push(32'hABCD_0012); outq.push_back(32'hABCD_0012);
      chk("R9 masked irq", 32'(irq), 0);
      rd(8'h30, 1, d); chk("R8 status", d, exp_status());
      wr(8'h34, 32'h0); mask_m = 0;
      chk("R9 unmasked irq", 32'(irq), 1);
      host_fetch(3);
      chk("R8 status cleared irq", 32'(irq), 0);
      host_fetch(1);
      rd(8'h30, 1, d); chk("R8 status empty", d, 0);
      ctl_push(32'h0000_1000); outq.push_back(32'h0000_1000);
      chk("R9 irq on push", 32'(irq), 1);
      wr(8'h34, 32'h0000_0008); mask_m = 32'h8;
      chk("R9 remask", 32'(irq), 0);
      host_fetch(1);

      // R10 doorbell
      wr(8'h20, 0); chk("R10 write 0 idle", 32'(db_cfg), 0);
      wr(8'h20, 1); chk("R10 set", 32'(db_cfg), 1);
      wr(8'h20, 0); chk("R10 write 0 holds", 32'(db_cfg), 1);
      rd(8'h20, 1, d); chk("R10 read back", d, 1);
      @(negedge clk); db_ack = 1; @(negedge clk); db_ack = 0;
      chk("R10 ack clears", 32'(db_cfg), 0);
      @(negedge clk); db_ack = 1; reg_wr_en = 1; reg_addr = 8'h20; reg_wdata = 1;
      @(negedge clk); db_ack = 0; reg_wr_en = 0;
      chk("R10 set beats ack", 32'(db_cfg), 1);

      // R11 zero reads
      host_post(32'h1111_2220);
      rd(8'h40, 1, d); chk("R11 post reg reads 0", d, 0);
      rd(8'h10, 1, d); chk("R11 unmapped reads 0", d, 0);
      rd(8'h7C, 1, d); chk("R11 unmapped high", d, 0);

      // R2 R3 fill inbound
      for (int i = 1; i < DEPTH; i++) host_post(32'h100 + 32'(i * 4));
      chk("R3 full no ovf", 32'(ib_ovf), 0);
      host_post(32'hDEAD_BEE0);
      chk("R3 ovf set", 32'(ib_ovf), 1);
      for (int i = 0; i < DEPTH; i++) drain_check("R2 drain");
      chk("R2 empty", 32'(ib_valid), 0);
      chk("R3 ovf sticky", 32'(ib_ovf), 1);

      // R6 fill outbound
      for (int i = 0; i < DEPTH; i++) begin
         ctl_push(32'h5000 + 32'(i * 4)); outq.push_back(32'h5000 + 32'(i * 4));
      end
      chk("R6 ready low", 32'(ob_ready), 0);
      ctl_push(32'hBAD0_0000);
      rd(8'h30, 1, d); chk("R8 status full", d, exp_status());
      for (int i = 0; i < DEPTH; i++) host_fetch(1 + (i % 2));
      host_fetch(1);
      chk("R6 ready again", 32'(ob_ready), 1);

      // random mix
      for (int it = 0; it < 400; it++) begin
         case ($urandom_range(0, 3))
            0: host_post($urandom() & 32'hFFFF_FFFC);
            1: drain_check("R2 random");
            2: begin
               d = ($urandom() & 32'hFFFF_FFFC) | ($urandom_range(0, 1) ? 32'h2 : 32'h0);
               chk("R6 random ready", 32'(ob_ready), 32'(outq.size() < DEPTH));
               ctl_push(d);
               if (outq.size() < DEPTH) outq.push_back(d);
            end
            default: host_fetch($urandom_range(1, 3));
         endcase
         if (it % 40 == 0) begin
            mask_m = $urandom_range(0, 1) ? 32'h0 : 32'hFFFF_FFFF;
            wr(8'h34, mask_m);
         end
         chk("R9 random irq", 32'(irq), 32'(exp_irq()));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule